// File: doc/BRIEF.md
# Rotate-and-Mask Shift Unit

This block is the 32-bit shifter of an integer execution stage. It is purely combinational: an operand, a shift amount, two mask boundary indices and an operation code go in, and a result word and a carry flag come out in the same cycle.

It offers four operations. The rotate-and-mask operation rotates the operand left and keeps only the bits inside a contiguous bit range, which may wrap around the word. The other three are register-count shifts: left logical, right logical and right arithmetic. The mask range is given by a first and a last bit index, where index 0 names the most significant bit of the word. The arithmetic right shift also reports whether a negative operand lost any 1 bits, so that a rounding-toward-zero divide by a power of two can be corrected.

Top module: `rotmask_unit`

## Requirements
- R1: With op_sel = 0 (rotate-and-mask), the result is src_a rotated left by shift_amt[4:0] and then ANDed with the generated mask; shift_amt[5] has no effect on this operation.
- R2: Mask indices count from the most significant end: index i selects port bit 31-i. When mask_first <= mask_last, the mask holds ones at indices mask_first through mask_last inclusive, and zeros elsewhere; no result bit outside that range is ever set.
- R3: A rotate by 0 with indices 0 through 23 keeps the upper 24 bits of src_a and clears the low 8 bits; a rotate by 24 with indices 0 through 7 places the low byte of src_a in the top byte and clears the rest.
- R4: When mask_first > mask_last, the mask wraps: ones run from mask_first to index 31 and from index 0 to mask_last. With mask_first = mask_last + 1 the mask is all ones.
- R5: With op_sel = 1 (left logical), the result is src_a shifted left by the 6-bit shift_amt with zeros entering at the low end; any count from 32 to 63 gives 0.
- R6: With op_sel = 2 (right logical), the result is src_a shifted right by the 6-bit shift_amt with zeros entering at the high end; any count from 32 to 63 gives 0.
- R7: With op_sel = 3 (right arithmetic), the result is src_a shifted right with copies of bit 31 entering at the high end; any count from 32 to 63 gives 32 copies of bit 31.
- R8: ca_out is 1 only for op_sel = 3 when src_a bit 31 is 1 and at least one 1 bit was shifted out (for counts of 32 or more, every bit counts as shifted out); in all other cases ca_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 32 | Operand to rotate or shift |
| shift_amt | input | 6 | Shift count; the rotate uses the low 5 bits |
| mask_first | input | 5 | Mask start index, 0 = most significant bit |
| mask_last | input | 5 | Mask end index, 0 = most significant bit |
| op_sel | input | 2 | 0 rotate-and-mask, 1 left logical, 2 right logical, 3 right arithmetic |
| result | output | 32 | Operation result |
| ca_out | output | 1 | Carry from the arithmetic right shift |

## Verification
The embedded checks watch, on every input change, that the mask population matches the span or wrapped span implied by its two indices, that rotation preserves the number of set bits, that no rotate-and-mask result bit lies outside the mask, that large counts flush the logical shifts and sign-fill the arithmetic one, and that the carry never rises for a non-negative operand or a non-arithmetic operation. Only the bench's directed cases can show that bits land in the right positions: the MSB-first index orientation, the byte-move and byte-clear examples, the exact wrap boundaries, the effect of each count on each shift, and whether the carry reflects exactly the lost bits.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  typedef enum logic [1:0] {
    RM_ROT_MASK = 2'd0,
    RM_SHL      = 2'd1,
    RM_SHR      = 2'd2,
    RM_SHRA     = 2'd3
  } rm_op_e;
endpackage

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
  parameter int WIDTH = 32,
  localparam int IW   = $clog2(WIDTH)
) (
  input  logic [IW-1:0]    first_idx,
  input  logic [IW-1:0]    last_idx,
  output logic [WIDTH-1:0] mask
);
  logic wrap;
  assign wrap = first_idx > last_idx;

  // Index k counts from the most significant end of the word.
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    localparam logic [IW-1:0] KI = IW'(k);
    logic ge_first, le_last;
    assign ge_first = KI >= first_idx;
    assign le_last  = KI <= last_idx;
    assign mask[WIDTH-1-k] = wrap ? (ge_first | le_last) : (ge_first & le_last);
  end

  always_comb begin
    if (!wrap) begin
      p_span_count_r2: assert ($countones(mask) == int'(last_idx) - int'(first_idx) + 1)
        else $error("mask span population wrong");
    end else begin
      p_wrap_count_r4: assert ($countones(mask) == WIDTH - (int'(first_idx) - int'(last_idx) - 1))
        else $error("wrapped mask population wrong");
    end
  end
endmodule

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int WIDTH = 32,
  localparam int IW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src,
  input  logic [IW-1:0]    amt,
  output logic [WIDTH-1:0] rot
);
  logic [2*WIDTH-1:0] doubled;
  assign doubled = {src, src} << amt;
  assign rot     = doubled[2*WIDTH-1:WIDTH];

  always_comb begin
    p_rot_keeps_ones_r1: assert ($countones(rot) == $countones(src))
      else $error("rotation changed bit population");
  end
endmodule

// File: rtl/rm_shifter.sv
module rm_shifter #(
  parameter int WIDTH = 32,
  localparam int IW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src,
  input  logic [IW:0]      cnt,
  output logic [WIDTH-1:0] shl,
  output logic [WIDTH-1:0] shr,
  output logic [WIDTH-1:0] sra,
  output logic             sra_ca
);
  logic          over;
  logic [IW-1:0] amt;
  logic          sign;
  logic [WIDTH-1:0] lost_mask;

  assign over = cnt[IW];
  assign amt  = cnt[IW-1:0];
  assign sign = src[WIDTH-1];

  assign shl = over ? '0 : (src << amt);
  assign shr = over ? '0 : (src >> amt);
  assign sra = over ? {WIDTH{sign}} : WIDTH'($signed(src) >>> amt);

  // Bits that leave the low end of a right shift.
  assign lost_mask = over ? {WIDTH{1'b1}} : ~({WIDTH{1'b1}} << amt);
  assign sra_ca    = sign & (|(src & lost_mask));

  always_comb begin
    p_ca_needs_sign_r8: assert (!sra_ca || src[WIDTH-1])
      else $error("carry raised for non-negative operand");
    p_flush_logical_r5: assert (!over || (shl == '0 && shr == '0))
      else $error("logical shift by large count not flushed");
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int WIDTH = 32,
  localparam int IW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src_a,
  input  logic [IW:0]      shift_amt,
  input  logic [IW-1:0]    mask_first,
  input  logic [IW-1:0]    mask_last,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             ca_out
);
  import rotmask_pkg::*;

  rm_op_e           op;
  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] rot;
  logic [WIDTH-1:0] shl, shr, sra;
  logic             sra_ca;

  assign op = rm_op_e'(op_sel);

  rm_mask_gen #(.WIDTH(WIDTH)) u_mask (
    .first_idx (mask_first),
    .last_idx  (mask_last),
    .mask      (mask)
  );

  rm_rotator #(.WIDTH(WIDTH)) u_rot (
    .src (src_a),
    .amt (shift_amt[IW-1:0]),
    .rot (rot)
  );

  rm_shifter #(.WIDTH(WIDTH)) u_shift (
    .src    (src_a),
    .cnt    (shift_amt),
    .shl    (shl),
    .shr    (shr),
    .sra    (sra),
    .sra_ca (sra_ca)
  );

  always_comb begin
    result = '0;
    ca_out = 1'b0;
    unique case (op)
      RM_ROT_MASK: result = rot & mask;
      RM_SHL:      result = shl;
      RM_SHR:      result = shr;
      RM_SHRA: begin
        result = sra;
        ca_out = sra_ca;
      end
      default: result = '0;
    endcase
  end

  always_comb begin
    p_inside_mask_r2: assert (op != RM_ROT_MASK || (result & ~mask) == '0)
      else $error("rotate result outside mask");
    p_sign_fill_r7: assert (!(op == RM_SHRA && shift_amt[IW]) || result == {WIDTH{src_a[WIDTH-1]}})
      else $error("arithmetic shift by large count not sign-filled");
    p_ca_only_sra_r8: assert (op == RM_SHRA || !ca_out)
      else $error("carry raised outside arithmetic shift");
  end
endmodule

// File: tb/rotmask_unit_test.sv
`timescale 1ns/1ps
module rotmask_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_a = '0;
  logic [5:0]  shift_amt = '0;
  logic [4:0]  mask_first = '0;
  logic [4:0]  mask_last = '0;
  logic [1:0]  op_sel = '0;
  logic [31:0] result;
  logic        ca_out;

  typedef struct {
    logic [31:0] res;
    logic        ca;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rotmask_unit uut (
    .src_a      (src_a),
    .shift_amt  (shift_amt),
    .mask_first (mask_first),
    .mask_last  (mask_last),
    .op_sel     (op_sel),
    .result     (result),
    .ca_out     (ca_out)
  );

  // Driver: apply one stimulus per cycle just after the rising edge.
  task automatic drive(input logic [1:0] op, input logic [5:0] amt,
                       input logic [4:0] mf, input logic [4:0] ml,
                       input logic [31:0] src, input logic [31:0] er,
                       input logic ec, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    op_sel = op; shift_amt = amt; mask_first = mf; mask_last = ml; src_a = src;
    e.res = er; e.ca = ec; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare at the falling edge.
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (result !== e.res || ca_out !== e.ca) begin
        bad++;
        $display("FAIL %s: result=%h ca=%b expected result=%h ca=%b",
                 e.tag, result, ca_out, e.res, e.ca);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs give zero outputs
    drive(2'd0, 6'd0, 5'd0, 5'd0, 32'h0, 32'h0, 1'b0, "R1");
    // R1: full mask, rotate by 8; bit 5 of count ignored for rotate
    drive(2'd0, 6'd8,  5'd0, 5'd31, 32'h12345678, 32'h34567812, 1'b0, "R1");
    drive(2'd0, 6'd40, 5'd0, 5'd31, 32'h12345678, 32'h34567812, 1'b0, "R1");
    // R2: single MSB-first index 31 is port bit 0; index 0 is port bit 31
    drive(2'd0, 6'd0, 5'd31, 5'd31, 32'hFFFFFFFF, 32'h00000001, 1'b0, "R2");
    drive(2'd0, 6'd0, 5'd0,  5'd0,  32'hFFFFFFFF, 32'h80000000, 1'b0, "R2");
    drive(2'd0, 6'd4, 5'd8,  5'd15, 32'hA5C3F00F, 32'h003F0000, 1'b0, "R2");
    // R3: byte move and low-byte clear
    drive(2'd0, 6'd24, 5'd0, 5'd7,  32'h12345678, 32'h78000000, 1'b0, "R3");
    drive(2'd0, 6'd0,  5'd0, 5'd23, 32'hDEADBEEF, 32'hDEADBE00, 1'b0, "R3");
    // R4: wrapped masks
    drive(2'd0, 6'd0, 5'd28, 5'd3, 32'hFFFFFFFF, 32'hF000000F, 1'b0, "R4");
    drive(2'd0, 6'd0, 5'd5,  5'd4, 32'h13579BDF, 32'h13579BDF, 1'b0, "R4");
    // R5: left logical
    drive(2'd1, 6'd4,  5'd0, 5'd0, 32'h80000001, 32'h00000010, 1'b0, "R5");
    drive(2'd1, 6'd31, 5'd0, 5'd0, 32'h00000001, 32'h80000000, 1'b0, "R5");
    drive(2'd1, 6'd32, 5'd0, 5'd0, 32'hFFFFFFFF, 32'h00000000, 1'b0, "R5");
    drive(2'd1, 6'd63, 5'd0, 5'd0, 32'hFFFFFFFF, 32'h00000000, 1'b0, "R5");
    // R6: right logical
    drive(2'd2, 6'd4,  5'd0, 5'd0, 32'h80000000, 32'h08000000, 1'b0, "R6");
    drive(2'd2, 6'd0,  5'd0, 5'd0, 32'hCAFEF00D, 32'hCAFEF00D, 1'b0, "R6");
    drive(2'd2, 6'd40, 5'd0, 5'd0, 32'hFFFFFFFF, 32'h00000000, 1'b0, "R6");
    // R7 / R8: right arithmetic and carry
    drive(2'd3, 6'd4,  5'd0, 5'd0, 32'h80000010, 32'hF8000001, 1'b0, "R7");
    drive(2'd3, 6'd4,  5'd0, 5'd0, 32'h80000011, 32'hF8000001, 1'b1, "R8");
    drive(2'd3, 6'd1,  5'd0, 5'd0, 32'h70000001, 32'h38000000, 1'b0, "R8");
    drive(2'd3, 6'd32, 5'd0, 5'd0, 32'h80000000, 32'hFFFFFFFF, 1'b1, "R7");
    drive(2'd3, 6'd33, 5'd0, 5'd0, 32'h7FFFFFFF, 32'h00000000, 1'b0, "R7");
    drive(2'd3, 6'd0,  5'd0, 5'd0, 32'h80000001, 32'h80000001, 1'b0, "R8");
    // R8: no carry from other operations with negative operand
    drive(2'd2, 6'd4, 5'd0, 5'd0, 32'h8000000F, 32'h08000000, 1'b0, "R8");
    drive(2'd0, 6'd1, 5'd0, 5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R8");
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule